// File: doc/BRIEF.md
# UART FIFO Status and DMA Handshake Unit

This unit holds the transmit and receive byte queues of one serial channel. Each queue is 32 entries deep by default. From the two occupancies it derives the line-status flags, the transmit and receive interrupt requests, and the two active-low DMA request lines (`txrdy_no`, `rxrdy_no`). A receiver pushes each byte with a 3-bit error tag: bit 0 parity, bit 1 framing, bit 2 break. The tag travels through the queue with its byte. A transmitter pops bytes and reports when its shift register is still busy.

The DMA lines have two signalling styles. The single-character style asserts a request per byte. The block style, which needs the queues enabled, is tied to a programmable receive trigger level: receive requests start when the level is reached, and the queue keeps accepting bytes until it is full. When the queues are disabled, each direction acts as a one-byte holding register. With the queues enabled and every interrupt enable cleared, the unit raises no interrupts and software polls the flags.

Top module: `uart_fifo_status`

## Requirements
- R1: `data_ready_o` is high exactly while the receive queue holds at least one byte.
- R2: `thr_empty_o` is high when the transmit queue is empty. `tx_empty_o` is high only when the transmit queue is empty and `tx_busy_i` is low.
- R3: A transmit push into a full queue changes nothing. A receive push into a full queue discards the byte and sets `overrun_o`. `overrun_o` stays set until a cycle with `status_rd_i` high and no new overrun.
- R4: `fifo_err_o` is high while any byte held in the receive queue carries a nonzero error tag.
- R5: `rx_trig_i` selects the trigger level. Code 0 gives 1 byte, 1 gives 8, 2 gives 16 and 3 gives 28.
- R6: Single-character style applies when `dma_mode_i`=0 or the queues are disabled. In this style `txrdy_no` is low while the transmit queue is empty, and `rxrdy_no` is low while the receive queue holds a byte.
- R7: Block style applies when `dma_mode_i`=1 and `fifo_en_i`=1. In this style `rxrdy_no` is low while receive occupancy is at or above the trigger level. `txrdy_no` is low while the transmit queue has a free entry and high when it is full.
- R8: `rx_irq_o` equals `int_en_i[0]` AND the receive condition. `tx_irq_o` equals `int_en_i[1]` AND the transmit condition. In block style the receive condition is occupancy at or above the trigger, and the transmit condition is occupancy below the trigger. In single-character style they are receive queue not empty and transmit queue empty.
- R9: With `fifo_en_i`=1 and `int_en_i`=0, both interrupt outputs stay low.
- R10: `tx_clear_i` or `rx_clear_i` empties its queue at the next edge, together with the receive error tags. A push or pop in the same cycle is ignored.
- R11: With `fifo_en_i`=0, a queue accepts a push only while its occupancy is zero.
- R12: In block style the receive queue accepts bytes past the trigger level until it holds 32.
- R13: Bytes leave each queue in arrival order. `tx_data_o`, `rx_data_o` and `rx_err_o` present the oldest entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_en_i | input | 1 | Queue enable; 0 gives one-byte holding registers |
| dma_mode_i | input | 1 | 0 single-character style, 1 block style |
| rx_trig_i | input | 2 | Receive trigger code |
| int_en_i | input | 4 | Interrupt enables: 0 rx data, 1 tx empty, 2 line status, 3 modem |
| status_rd_i | input | 1 | Status read strobe, clears overrun |
| tx_clear_i | input | 1 | Transmit queue clear strobe |
| rx_clear_i | input | 1 | Receive queue clear strobe |
| tx_push_i | input | 1 | Transmit write strobe |
| tx_data_i | input | 8 | Transmit write byte |
| tx_pop_i | input | 1 | Transmitter takes the oldest byte |
| tx_busy_i | input | 1 | Transmit shift register busy |
| tx_data_o | output | 8 | Oldest transmit byte |
| rx_push_i | input | 1 | Receiver delivers a byte |
| rx_data_i | input | 8 | Received byte |
| rx_err_i | input | 3 | Error tag of received byte |
| rx_pop_i | input | 1 | Host reads the oldest received byte |
| rx_data_o | output | 8 | Oldest received byte |
| rx_err_o | output | 3 | Error tag of oldest received byte |
| tx_count_o | output | 6 | Transmit occupancy |
| rx_count_o | output | 6 | Receive occupancy |
| data_ready_o | output | 1 | Receive data available |
| thr_empty_o | output | 1 | Transmit queue empty |
| tx_empty_o | output | 1 | Transmit queue and shifter empty |
| overrun_o | output | 1 | Sticky receive overrun |
| fifo_err_o | output | 1 | Some queued byte has an error tag |
| tx_irq_o | output | 1 | Transmit interrupt request |
| rx_irq_o | output | 1 | Receive interrupt request |
| txrdy_no | output | 1 | Transmit DMA request, active low |
| rxrdy_no | output | 1 | Receive DMA request, active low |

## Verification
The hardest state to reach is a receive queue holding exactly 28 bytes in block style with a high trigger. In the same cycle the host pops a tagged byte while the receiver pushes a clean one, and an overrun must still be caught at 32. The stimulus gets there by filling the queue byte by byte for each trigger code and sampling the interrupt and DMA lines at every step. It then overfills the queue and drains it, and finishes with a long stretch of random pushes, pops, clears and mode changes. A queue model in the bench follows every cycle of it.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

  typedef enum logic [1:0] {
    TRIG_ONE  = 2'd0,
    TRIG_QTR  = 2'd1,
    TRIG_HALF = 2'd2,
    TRIG_HIGH = 2'd3
  } rx_trig_e;

  // trigger levels scale with depth: 1, 1/4, 1/2, 7/8
  function automatic int unsigned trig_bytes(input rx_trig_e code, input int unsigned depth);
    unique case (code)
      TRIG_ONE:  return 1;
      TRIG_QTR:  return depth / 4;
      TRIG_HALF: return depth / 2;
      default:   return depth - depth / 8;
    endcase
  endfunction

endpackage

// File: rtl/uart_byte_fifo.sv
module uart_byte_fifo #(
  parameter  int DW    = 8,
  parameter  int DEPTH = 32,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          single_i,
  input  logic          clear_i,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic [DW-1:0] data_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          push_ok_o,
  output logic          pop_ok_o,
  output logic          drop_o
);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] count_q, cap;

  assign cap       = single_i ? CW'(1) : CW'(DEPTH);
  assign full_o    = count_q >= cap;
  assign push_ok_o = push_i & ~full_o & ~clear_i;
  assign pop_ok_o  = pop_i & (count_q != '0) & ~clear_i;
  assign drop_o    = push_i & full_o & ~clear_i;
  assign data_o    = mem_q[rd_ptr_q];
  assign count_o   = count_q;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_ok_o) mem_q[wr_ptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else if (clear_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (push_ok_o) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop_ok_o)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      unique case ({push_ok_o, pop_ok_o})
        2'b10:   count_q <= count_q + CW'(1);
        2'b01:   count_q <= count_q - CW'(1);
        default: count_q <= count_q;
      endcase
    end
  end

  p_full_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i && !clear_i) |=> (count_o == $past(count_o)));

  p_clear_empty_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (count_o == '0));

  p_single_cap_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (single_i && count_o <= CW'(1)) |=> (count_o <= CW'(1)));

endmodule

// File: rtl/uart_dma_ready.sv
module uart_dma_ready #(
  parameter  int DEPTH = 32,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fifo_en_i,
  input  logic          dma_mode_i,
  input  logic [1:0]    rx_trig_i,
  input  logic [3:0]    int_en_i,
  input  logic [CW-1:0] tx_count_i,
  input  logic [CW-1:0] rx_count_i,
  output logic          tx_irq_o,
  output logic          rx_irq_o,
  output logic          txrdy_no,
  output logic          rxrdy_no
);
  import uart_fifo_pkg::*;

  logic          block_mode, polled;
  logic [CW-1:0] trig;
  logic          rx_at_trig, tx_below_trig, tx_none, rx_some, tx_full;

  assign block_mode    = fifo_en_i & dma_mode_i;
  assign polled        = fifo_en_i & (int_en_i == 4'b0000);
  assign trig          = CW'(trig_bytes(rx_trig_e'(rx_trig_i), DEPTH));
  assign rx_at_trig    = rx_count_i >= trig;
  assign tx_below_trig = tx_count_i < trig;
  assign tx_none       = tx_count_i == '0;
  assign rx_some       = rx_count_i != '0;
  assign tx_full       = tx_count_i >= CW'(DEPTH);

  always_comb begin
    if (block_mode) begin
      rxrdy_no = ~rx_at_trig;
      txrdy_no = tx_full;
      rx_irq_o = int_en_i[0] & ~polled & rx_at_trig;
      tx_irq_o = int_en_i[1] & ~polled & tx_below_trig;
    end else begin
      rxrdy_no = ~rx_some;
      txrdy_no = ~tx_none;
      rx_irq_o = int_en_i[0] & ~polled & rx_some;
      tx_irq_o = int_en_i[1] & ~polled & tx_none;
    end
  end

  p_blk_full_rx_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (block_mode && rx_count_i == CW'(DEPTH)) |-> !rxrdy_no);

  p_polled_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_en_i && int_en_i == 4'b0000) |-> (!tx_irq_o && !rx_irq_o));

endmodule

// File: rtl/uart_fifo_status.sv
module uart_fifo_status #(
  parameter  int DEPTH = 32,
  parameter  int DW    = 8,
  parameter  int EW    = 3,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fifo_en_i,
  input  logic          dma_mode_i,
  input  logic [1:0]    rx_trig_i,
  input  logic [3:0]    int_en_i,
  input  logic          status_rd_i,
  input  logic          tx_clear_i,
  input  logic          rx_clear_i,
  input  logic          tx_push_i,
  input  logic [DW-1:0] tx_data_i,
  input  logic          tx_pop_i,
  input  logic          tx_busy_i,
  output logic [DW-1:0] tx_data_o,
  input  logic          rx_push_i,
  input  logic [DW-1:0] rx_data_i,
  input  logic [EW-1:0] rx_err_i,
  input  logic          rx_pop_i,
  output logic [DW-1:0] rx_data_o,
  output logic [EW-1:0] rx_err_o,
  output logic [CW-1:0] tx_count_o,
  output logic [CW-1:0] rx_count_o,
  output logic          data_ready_o,
  output logic          thr_empty_o,
  output logic          tx_empty_o,
  output logic          overrun_o,
  output logic          fifo_err_o,
  output logic          tx_irq_o,
  output logic          rx_irq_o,
  output logic          txrdy_no,
  output logic          rxrdy_no
);

  logic             single;
  logic             tx_full, tx_push_ok, tx_pop_ok, tx_drop;
  logic             rx_full, rx_push_ok, rx_pop_ok, rx_drop;
  logic [DW+EW-1:0] rx_head;
  logic             ovr_q;
  logic [CW-1:0]    err_cnt_q;
  logic             err_in, err_out;

  assign single = ~fifo_en_i;

  uart_byte_fifo #(.DW(DW), .DEPTH(DEPTH)) u_tx_fifo (
    .clk_i, .rst_ni,
    .single_i (single),
    .clear_i  (tx_clear_i),
    .push_i   (tx_push_i),
    .data_i   (tx_data_i),
    .pop_i    (tx_pop_i),
    .data_o   (tx_data_o),
    .count_o  (tx_count_o),
    .full_o   (tx_full),
    .push_ok_o(tx_push_ok),
    .pop_ok_o (tx_pop_ok),
    .drop_o   (tx_drop)
  );

  uart_byte_fifo #(.DW(DW + EW), .DEPTH(DEPTH)) u_rx_fifo (
    .clk_i, .rst_ni,
    .single_i (single),
    .clear_i  (rx_clear_i),
    .push_i   (rx_push_i),
    .data_i   ({rx_err_i, rx_data_i}),
    .pop_i    (rx_pop_i),
    .data_o   (rx_head),
    .count_o  (rx_count_o),
    .full_o   (rx_full),
    .push_ok_o(rx_push_ok),
    .pop_ok_o (rx_pop_ok),
    .drop_o   (rx_drop)
  );

  uart_dma_ready #(.DEPTH(DEPTH)) u_dma (
    .clk_i, .rst_ni,
    .fifo_en_i, .dma_mode_i, .rx_trig_i, .int_en_i,
    .tx_count_i(tx_count_o),
    .rx_count_i(rx_count_o),
    .tx_irq_o, .rx_irq_o, .txrdy_no, .rxrdy_no
  );

  assign rx_data_o = rx_head[DW-1:0];
  assign rx_err_o  = rx_head[DW+EW-1:DW];

  // count of tagged bytes in the rx queue replaces a scan of all tags
  assign err_in  = rx_push_ok & (|rx_err_i);
  assign err_out = rx_pop_ok & (|rx_err_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_cnt_q <= '0;
      ovr_q     <= 1'b0;
    end else begin
      if (rx_clear_i) err_cnt_q <= '0;
      else unique case ({err_in, err_out})
        2'b10:   err_cnt_q <= err_cnt_q + CW'(1);
        2'b01:   err_cnt_q <= err_cnt_q - CW'(1);
        default: err_cnt_q <= err_cnt_q;
      endcase
      if (rx_drop)          ovr_q <= 1'b1;
      else if (status_rd_i) ovr_q <= 1'b0;
    end
  end

  assign data_ready_o = rx_count_o != '0;
  assign thr_empty_o  = tx_count_o == '0;
  assign tx_empty_o   = thr_empty_o & ~tx_busy_i;
  assign overrun_o    = ovr_q;
  assign fifo_err_o   = err_cnt_q != '0;

  p_overrun_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_push_i && rx_full && !rx_clear_i) |=> overrun_o);

  p_err_empty_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_count_o == '0) |-> !fifo_err_o);

  p_tx_drop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_drop && !tx_pop_ok) |=> $stable(tx_count_o));

  p_err_le_count_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_cnt_q <= rx_count_o);

endmodule

// File: tb/uart_fifo_status_bench.sv
module uart_fifo_status_bench;

  localparam int DEPTH = 32;

  logic       clk_i = 0, rst_ni = 0;
  logic       fifo_en_i = 1, dma_mode_i = 0, status_rd_i = 0;
  logic [1:0] rx_trig_i = 0;
  logic [3:0] int_en_i = 0;
  logic       tx_clear_i = 0, rx_clear_i = 0;
  logic       tx_push_i = 0, tx_pop_i = 0, tx_busy_i = 0;
  logic [7:0] tx_data_i = 0, rx_data_i = 0;
  logic       rx_push_i = 0, rx_pop_i = 0;
  logic [2:0] rx_err_i = 0;
  logic [7:0] tx_data_o, rx_data_o;
  logic [2:0] rx_err_o;
  logic [5:0] tx_count_o, rx_count_o;
  logic       data_ready_o, thr_empty_o, tx_empty_o, overrun_o, fifo_err_o;
  logic       tx_irq_o, rx_irq_o, txrdy_no, rxrdy_no;

  uart_fifo_status u_uart_fifo_status (.*);

  always #10 clk_i = ~clk_i;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0]  tx_q[$];
  logic [10:0] rx_q[$];
  bit          ovr_m = 0;
  int          trig_tab[4] = '{1, 8, 16, 28};

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit any_err();
    foreach (rx_q[i]) if (rx_q[i][10:8] != 0) return 1;
    return 0;
  endfunction

  task automatic model_update();
    int cap = fifo_en_i ? DEPTH : 1;
    bit tfull = tx_q.size() >= cap, rfull = rx_q.size() >= cap;
    bit tne = tx_q.size() != 0, rne = rx_q.size() != 0;
    if (tx_clear_i) tx_q.delete();
    else begin
      if (tx_pop_i && tne) void'(tx_q.pop_front());
      if (tx_push_i && !tfull) tx_q.push_back(tx_data_i);
    end
    if (rx_push_i && rfull && !rx_clear_i) ovr_m = 1;
    else if (status_rd_i) ovr_m = 0;
    if (rx_clear_i) rx_q.delete();
    else begin
      if (rx_pop_i && rne) void'(rx_q.pop_front());
      if (rx_push_i && !rfull) rx_q.push_back({rx_err_i, rx_data_i});
    end
  endtask

  task automatic compare();
    int  tn = tx_q.size(), rn = rx_q.size();
    bit  blk = fifo_en_i && dma_mode_i;
    int  tg = trig_tab[rx_trig_i];
    bit  pol = fifo_en_i && int_en_i == 0;
    string dreq = blk ? "R7" : "R6";
    string ireq = pol ? "R9" : "R8";
    chk("R10", "tx_count", tx_count_o, tn);
    chk("R10", "rx_count", rx_count_o, rn);
    chk("R1", "data_ready", data_ready_o, rn != 0);
    chk("R2", "thr_empty", thr_empty_o, tn == 0);
    chk("R2", "tx_empty", tx_empty_o, tn == 0 && !tx_busy_i);
    chk("R3", "overrun", overrun_o, ovr_m);
    chk("R4", "fifo_err", fifo_err_o, any_err());
    chk(dreq, "rxrdy_n", rxrdy_no, blk ? !(rn >= tg) : rn == 0);
    chk(dreq, "txrdy_n", txrdy_no, blk ? tn >= DEPTH : tn != 0);
    chk(ireq, "rx_irq", rx_irq_o, !pol && int_en_i[0] && (blk ? rn >= tg : rn != 0));
    chk(ireq, "tx_irq", tx_irq_o, !pol && int_en_i[1] && (blk ? tn < tg : tn == 0));
    if (rn != 0) chk("R13", "rx_head", {rx_err_o, rx_data_o}, rx_q[0]);
    if (tn != 0) chk("R13", "tx_head", tx_data_o, tx_q[0]);
  endtask

  task automatic step();
    @(posedge clk_i);
    model_update();
    @(negedge clk_i);
    compare();
  endtask

  task automatic rx_put(input logic [7:0] d, input logic [2:0] e);
    rx_push_i = 1; rx_data_i = d; rx_err_i = e; step(); rx_push_i = 0; rx_err_i = 0;
  endtask

  task automatic tx_put(input logic [7:0] d);
    tx_push_i = 1; tx_data_i = d; step(); tx_push_i = 0;
  endtask

  task automatic clear_both();
    tx_clear_i = 1; rx_clear_i = 1; step(); tx_clear_i = 0; rx_clear_i = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #5;
    compare();  // reset state
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    step();

    // single-character style, interrupts on
    int_en_i = 4'b0011;
    rx_put(8'h11, 3'b000);
    rx_put(8'h22, 3'b001);
    rx_put(8'h33, 3'b100);
    chk("R4", "fifo_err after tagged push", fifo_err_o, 1);
    rx_pop_i = 1; step(); step();
    chk("R13", "third rx byte", rx_data_o, 8'h33);
    step(); rx_pop_i = 0;
    chk("R1", "data_ready after drain", data_ready_o, 0);
    tx_busy_i = 1;
    tx_put(8'hA5); tx_put(8'h5A);
    tx_pop_i = 1; step(); step(); tx_pop_i = 0;
    chk("R2", "tx_empty while busy", tx_empty_o, 0);
    tx_busy_i = 0; step();

    // polled mode
    int_en_i = 0;
    rx_put(8'h44, 0); tx_put(8'h01);
    chk("R9", "polled rx_irq", rx_irq_o, 0);
    clear_both();

    // block style, each trigger code
    dma_mode_i = 1; int_en_i = 4'b0001;
    for (int c = 0; c < 4; c++) begin
      rx_trig_i = 2'(c);
      for (int n = 1; n <= DEPTH; n++) begin
        rx_put(8'(n), 3'(n % 5 == 0));
        if (n == trig_tab[c] - 1) chk("R5", "irq below trigger", rx_irq_o, 0);
        if (n == trig_tab[c])     chk("R5", "irq at trigger", rx_irq_o, 1);
      end
      chk("R12", "rx holds full depth", rx_count_o, DEPTH);
      rx_put(8'hEE, 0);
      chk("R3", "overrun on full push", overrun_o, 1);
      status_rd_i = 1; step(); status_rd_i = 0;
      chk("R3", "overrun cleared", overrun_o, 0);
      rx_pop_i = 1; rx_push_i = 1; rx_data_i = 8'h77; step();
      rx_pop_i = 0; rx_push_i = 0;
      rx_clear_i = 1; rx_push_i = 1; step(); rx_clear_i = 0; rx_push_i = 0;
      chk("R10", "rx cleared", rx_count_o, 0);
      chk("R10", "err tags cleared", fifo_err_o, 0);
    end
    for (int n = 0; n < DEPTH + 2; n++) tx_put(8'(n + 100));
    chk("R7", "txrdy high when full", txrdy_no, 1);
    chk("R3", "tx full push ignored", tx_count_o, DEPTH);
    tx_pop_i = 1; step(); tx_pop_i = 0;
    chk("R7", "txrdy low with space", txrdy_no, 0);
    clear_both();

    // queues disabled
    fifo_en_i = 0;
    rx_put(8'h90, 0); rx_put(8'h91, 0);
    chk("R11", "rx capacity one", rx_count_o, 1);
    chk("R13", "first byte kept", rx_data_o, 8'h90);
    tx_put(8'h92); tx_put(8'h93);
    chk("R11", "tx capacity one", tx_count_o, 1);
    chk("R6", "txrdy holding full", txrdy_no, 1);
    clear_both();
    status_rd_i = 1; step(); status_rd_i = 0;

    // random traffic
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(0, 199) == 0) begin
        fifo_en_i = ($urandom_range(0, 3) != 0);
        dma_mode_i = 1'($urandom);
        rx_trig_i = 2'($urandom);
        int_en_i = 4'($urandom);
      end
      tx_push_i = ($urandom_range(0, 9) < 5);
      tx_data_i = 8'($urandom);
      tx_pop_i = ($urandom_range(0, 9) < 4);
      tx_busy_i = 1'($urandom);
      rx_push_i = ($urandom_range(0, 9) < 5);
      rx_data_i = 8'($urandom);
      rx_err_i = ($urandom_range(0, 3) == 0) ? 3'($urandom) : 3'b0;
      rx_pop_i = ($urandom_range(0, 9) < 4);
      status_rd_i = ($urandom_range(0, 19) == 0);
      tx_clear_i = ($urandom_range(0, 299) == 0);
      rx_clear_i = ($urandom_range(0, 299) == 0);
      step();
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule